// File: doc/BRIEF.md
# Clock Source Switch with Failure Monitor

This block picks the system clock from one of two sources: an on-chip RC oscillator, which is always running and serves as the reference, and an external oscillator that software may choose instead. After reset the RC oscillator drives the output. Changing the source goes through a glitch-free hand-over. The old source's gate closes on a low phase, and only after that closure has been synchronized back does the new source's gate open. The output therefore never shows a shortened high or low phase.

While the external source is requested, a watchdog clocked by the RC oscillator counts reference cycles between observed external edges. If the external clock stays quiet for a fixed number of reference cycles, the block records a failure and drops the external selection with no software action. It also forcibly closes the external gate, because a dead clock could not close that gate itself. The failure flag stays set until software clears it. While the flag is set, requests for the external source are ignored. An interrupt line reports the flag when the interrupt is enabled.

Top module: `clk_src_switch`

## Requirements
- R1: After reset `clk_sys` follows `clk_int`, and `src_is_ext`, `fail_flag` and `irq` are all 0.
- R2: Holding `sel_ext_req` at 1 with `fail_flag` at 0 moves `clk_sys` to `clk_ext`. `src_is_ext` becomes 1 only once the external gate is open, within 25 reference cycles.
- R3: Returning `sel_ext_req` to 0 moves `clk_sys` back to `clk_int`, and `src_is_ext` returns to 0 within 25 reference cycles.
- R4: No high or low phase of `clk_sys` is shorter than the shorter half-period of the two sources, across every switch, including a forced fallback.
- R5: With `mon_en` at 1 and the external source requested, an external clock that stops toggling sets `fail_flag` after FAIL_CYCLES (default 8) quiet reference cycles. The flag is not set within the first 3 cycles after the stop. Then `clk_sys` returns to `clk_int` and `src_is_ext` returns to 0 with no change on any input.
- R6: An external clock that keeps running never sets `fail_flag`.
- R7: `fail_flag` stays at 1 until a one-cycle pulse on `fail_clr` is sampled. It is 0 from the next reference edge on. A detection in the same cycle as the clear wins.
- R8: While `fail_flag` is 1, `sel_ext_req` at 1 has no effect: `src_is_ext` stays 0 and `clk_sys` keeps the reference period. Once the flag is cleared, a request still held is honoured.
- R9: `irq` is 1 exactly when `fail_flag` is 1 and `irq_en` is 1.
- R10: With `mon_en` at 0, a stopped external clock never sets `fail_flag`.
- R11: Requesting the external source while it is already dead also ends in a failure, and `clk_sys` recovers on `clk_int`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | On-chip RC clock; reference for control and monitoring |
| clk_ext | input | 1 | External oscillator clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_int |
| sel_ext_req | input | 1 | Level request: 1 asks for the external source |
| mon_en | input | 1 | Enables the external clock watchdog |
| irq_en | input | 1 | Lets the failure flag reach `irq` |
| fail_clr | input | 1 | One-cycle pulse that clears the failure flag |
| clk_sys | output | 1 | Selected system clock |
| src_is_ext | output | 1 | 1 when the external source is driving `clk_sys` |
| fail_flag | output | 1 | Sticky record of an external clock failure |
| irq | output | 1 | Failure interrupt, level |

## Verification
The bench stops the external clock in three situations: while it is selected, while a request for it is still in hand-over, and with the watchdog off. A design without the forced gate closure would leave `clk_sys` frozen after a failure, and the period checks would hang into the watchdog. A design with both gates open at once, or with a stale synchronizer value after the clear, produces runt phases, which a pulse-width tracker on `clk_sys` records. The bench also holds the request high through the whole sticky-flag period. A design that let the request through would show `src_is_ext` rising before the clear, and one that lost the flag early would show it at 0.

// File: rtl/clksw_pkg.sv
// Package: shared types and helpers for the clock source switch.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package clksw_pkg;

    // Which oscillator is currently driving the system clock.
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    // Bits needed for a counter that must hold the value n.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/clksw_sync.sv
// Module: clksw_sync
// A multi-flop synchronizer for a single level signal.
// ASYNC_CLR selects the reset variant. At 0, rst_n is sampled synchronously. At 1, rst_n
// clears the chain at once, for domains whose clock may be absent.
// Assumes STAGES >= 2 and that d is a level held for several destination cycles.
module clksw_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RST_VAL   = 1'b0,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain;

    generate
        if (ASYNC_CLR) begin : g_async
            // Shift the level in; cleared immediately when rst_n falls.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[TOP-1:0], d};
            end
        end else begin : g_sync
            // Shift the level in; reset sampled on the clock edge.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[TOP-1:0], d};
            end
        end
    endgenerate

    assign q = chain[TOP];

endmodule

// File: rtl/clksw_ctrl.sv
// Module: clksw_ctrl
// Reference-domain control: the granted selection, the sticky failure flag, the run
// permit for the external domain, and the interrupt.
// Assumes every input is synchronous to clk.
module clksw_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_req,
    input  logic fail_det,
    input  logic fail_clr,
    input  logic irq_en,
    output logic sel_q,
    output logic fail_flag,
    output logic ext_run,
    output logic irq
);
    logic flag_nxt;

    // Next flag value: set on detection, which takes priority over the clear.
    always_comb begin
        flag_nxt = fail_det | (fail_flag & ~fail_clr);
    end

    // Register the selection (blocked by the flag), the flag and the external run permit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 1'b0;
            fail_flag <= 1'b0;
            ext_run   <= 1'b0;
        end else begin
            sel_q     <= sel_req & ~fail_det & ~fail_flag;
            fail_flag <= flag_nxt;
            ext_run   <= ~flag_nxt;
        end
    end

    assign irq = fail_flag & irq_en;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !fail_clr) |=> fail_flag) else $error("flag dropped"); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && fail_clr && !fail_det) |=> !fail_flag) else $error("clear lost"); // R7
    AST_SEL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        fail_flag |-> !sel_q) else $error("select while flagged"); // R8

endmodule

// File: rtl/clksw_fail_mon.sv
// Module: clksw_fail_mon
// External clock watchdog. A toggle flop in the external domain halves that clock. Its
// level is synchronized into the reference domain, where each change resets a quiet
// counter. FAIL_CYCLES quiet reference cycles while active raise fail_det for one cycle.
// Assumes the external clock is not an exact even multiple of the reference. ext_run
// clears the toggle flop without needing clk_ext.
module clksw_fail_mon #(
    parameter int unsigned FAIL_CYCLES = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_int,
    input  logic rst_n,
    input  logic clk_ext,
    input  logic ext_run,
    input  logic mon_en,
    input  logic sel_q,
    output logic fail_det
);
    import clksw_pkg::*;

    localparam int unsigned CW = cnt_bits(FAIL_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(FAIL_CYCLES - 1);

    logic          tgl;
    logic          tgl_s;
    logic          tgl_d;
    logic          edge_seen;
    logic          active;
    logic [CW-1:0] quiet_cnt;

    // Halve the external clock so that its activity survives sampling.
    always_ff @(posedge clk_ext or negedge ext_run) begin
        if (!ext_run) tgl <= 1'b0;
        else          tgl <= ~tgl;
    end

    clksw_sync #(
        .STAGES   (SYNC_STAGES),
        .RST_VAL  (1'b0),
        .ASYNC_CLR(1'b0)
    ) u_tgl_sync (
        .clk  (clk_int),
        .rst_n(rst_n),
        .d    (tgl),
        .q    (tgl_s)
    );

    // Delay the synchronized toggle to detect its changes.
    always_ff @(posedge clk_int) begin
        if (!rst_n) tgl_d <= 1'b0;
        else        tgl_d <= tgl_s;
    end

    assign edge_seen = tgl_s ^ tgl_d;
    assign active    = mon_en & sel_q;

    // Count reference cycles since the last external activity; saturates at LAST.
    always_ff @(posedge clk_int) begin
        if (!rst_n || !active || edge_seen) quiet_cnt <= '0;
        else if (quiet_cnt != LAST)         quiet_cnt <= quiet_cnt + 1'b1;
    end

    assign fail_det = active & ~edge_seen & (quiet_cnt == LAST);

    AST_DET_AFTER_ACTIVE: assert property (@(posedge clk_int) disable iff (!rst_n)
        fail_det |-> $past(active)) else $error("detect without watch"); // R5
    AST_DET_BREAKS_SEL: assert property (@(posedge clk_int) disable iff (!rst_n)
        fail_det |=> !sel_q) else $error("select survived failure"); // R5

endmodule

// File: rtl/clksw_gf_mux.sv
// Module: clksw_gf_mux
// Glitch-free two-source clock multiplexer. Each source has a gate enable that changes
// only in that source's low phase (negative-edge flop). A gate may open only after the
// other gate's closure is seen through a synchronizer. ext_run low clears the external
// side at once; that side's copy of the internal enable clears to 1 ("internal busy"),
// so the external gate cannot open before the real state has been synchronized.
// Assumes sel is a level from the clk_int domain.
module clksw_gf_mux #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_int,
    input  logic rst_n,
    input  logic clk_ext,
    input  logic ext_run,
    input  logic sel,
    output logic clk_sys,
    output logic ext_active
);
    logic int_s1;
    logic en_int;
    logic ext_s1;
    logic en_ext;
    logic en_ext_s;
    logic en_int_x;

    clksw_sync #(
        .STAGES   (SYNC_STAGES),
        .RST_VAL  (1'b0),
        .ASYNC_CLR(1'b0)
    ) u_ext2int (
        .clk  (clk_int),
        .rst_n(rst_n),
        .d    (en_ext),
        .q    (en_ext_s)
    );

    clksw_sync #(
        .STAGES   (SYNC_STAGES),
        .RST_VAL  (1'b1),
        .ASYNC_CLR(1'b1)
    ) u_int2ext (
        .clk  (clk_ext),
        .rst_n(ext_run),
        .d    (en_int),
        .q    (en_int_x)
    );

    // Internal side: request to open while internal is wanted and external is closed.
    always_ff @(posedge clk_int) begin
        if (!rst_n) int_s1 <= 1'b1;
        else        int_s1 <= ~sel & ~en_ext_s;
    end

    // Internal gate enable, moved only while clk_int is low.
    always_ff @(negedge clk_int) begin
        if (!rst_n) en_int <= 1'b1;
        else        en_int <= int_s1;
    end

    // External side: request to open while external is wanted and internal is closed.
    always_ff @(posedge clk_ext or negedge ext_run) begin
        if (!ext_run) ext_s1 <= 1'b0;
        else          ext_s1 <= sel & ~en_int_x;
    end

    // External gate enable, moved only while clk_ext is low or forced shut.
    always_ff @(negedge clk_ext or negedge ext_run) begin
        if (!ext_run) en_ext <= 1'b0;
        else          en_ext <= ext_s1;
    end

    assign clk_sys    = (clk_int & en_int) | (clk_ext & en_ext);
    assign ext_active = en_ext_s;

    AST_ONE_GATE: assert property (@(posedge clk_int) disable iff (!rst_n)
        $onehot0({en_int, en_ext_s})) else $error("both gates open"); // R4

endmodule

// File: rtl/clk_src_switch.sv
// Module: clk_src_switch (top)
// Selects the system clock between the on-chip RC clock and an external oscillator,
// watches the external clock and falls back to the RC clock when it stops.
// Assumes clk_int always runs and that rst_n, sel_ext_req, mon_en, irq_en and
// fail_clr are synchronous to clk_int.
module clk_src_switch #(
    parameter int unsigned FAIL_CYCLES = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_int,
    input  logic clk_ext,
    input  logic rst_n,
    input  logic sel_ext_req,
    input  logic mon_en,
    input  logic irq_en,
    input  logic fail_clr,
    output logic clk_sys,
    output logic src_is_ext,
    output logic fail_flag,
    output logic irq
);
    import clksw_pkg::*;

    logic     sel_q;
    logic     fail_det;
    logic     ext_run;
    logic     ext_active;
    clk_src_e cur_src;

    clksw_ctrl u_ctrl (
        .clk      (clk_int),
        .rst_n    (rst_n),
        .sel_req  (sel_ext_req),
        .fail_det (fail_det),
        .fail_clr (fail_clr),
        .irq_en   (irq_en),
        .sel_q    (sel_q),
        .fail_flag(fail_flag),
        .ext_run  (ext_run),
        .irq      (irq)
    );

    clksw_fail_mon #(
        .FAIL_CYCLES(FAIL_CYCLES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk_int (clk_int),
        .rst_n   (rst_n),
        .clk_ext (clk_ext),
        .ext_run (ext_run),
        .mon_en  (mon_en),
        .sel_q   (sel_q),
        .fail_det(fail_det)
    );

    clksw_gf_mux #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mux (
        .clk_int   (clk_int),
        .rst_n     (rst_n),
        .clk_ext   (clk_ext),
        .ext_run   (ext_run),
        .sel       (sel_q),
        .clk_sys   (clk_sys),
        .ext_active(ext_active)
    );

    // Status reflects the synchronized gate state, not the request.
    always_comb begin
        cur_src = ext_active ? SRC_EXT : SRC_INT;
    end

    assign src_is_ext = (cur_src == SRC_EXT);

    AST_FLAG_NEEDS_MON: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(fail_flag) |-> $past(mon_en)) else $error("flag without monitor"); // R10

endmodule

// File: tb/clk_src_switch_tb.sv
`timescale 1ns/1ps
module clk_src_switch_tb;

    logic clk_int = 1'b0;
    logic clk_ext = 1'b0;
    logic ext_on  = 1'b1;
    logic rst_n, sel_ext_req, mon_en, irq_en, fail_clr;
    logic clk_sys, src_is_ext, fail_flag, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk_int = ~clk_int;
    always #4.0 if (ext_on) clk_ext = ~clk_ext;

    clk_src_switch u_dut (
        .clk_int    (clk_int),
        .clk_ext    (clk_ext),
        .rst_n      (rst_n),
        .sel_ext_req(sel_ext_req),
        .mon_en     (mon_en),
        .irq_en     (irq_en),
        .fail_clr   (fail_clr),
        .clk_sys    (clk_sys),
        .src_is_ext (src_is_ext),
        .fail_flag  (fail_flag),
        .irq        (irq)
    );

    // Pulse-width tracker on the system clock.
    real last_t = 0.0;
    real min_w  = 1000.0;
    bit  armed  = 1'b0;
    bit  primed = 1'b0;
    always @(clk_sys) begin
        if (armed) begin
            if (primed && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
            primed = 1'b1;
        end
        last_t = $realtime;
    end

    function automatic logic exp_src(input logic req, input logic flag);
        return req & ~flag;
    endfunction

    function automatic logic exp_irq(input logic flag, input logic en);
        return flag & en;
    endfunction

    function automatic int exp_period(input logic src);
        return src ? 80 : 50;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_int);
    endtask

    // Period of clk_sys in tenths of a ns.
    task automatic chk_period(input string tag, input int exp);
        real t0;
        @(posedge clk_sys);
        @(posedge clk_sys);
        t0 = $realtime;
        @(posedge clk_sys);
        chk(tag, $rtoi(($realtime - t0) * 10.0 + 0.5), exp);
        @(negedge clk_int);
    endtask

    task automatic pulse_clr;
        fail_clr = 1'b1;
        @(negedge clk_int);
        fail_clr = 1'b0;
    endtask

    initial begin
        #500000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'h5EED_C10C);
        rst_n = 0; sel_ext_req = 0; mon_en = 0; irq_en = 0; fail_clr = 0;
        wait_cyc(10);
        rst_n = 1;
        wait_cyc(3);
        // R1 reset state
        chk("R1 src", src_is_ext, 0);
        chk("R1 flag", fail_flag, 0);
        chk("R1 irq", irq, 0);
        chk_period("R1 period", exp_period(0));
        armed = 1'b1;

        // R2 / R3 switch over and back
        mon_en = 1; sel_ext_req = 1;
        wait_cyc(30);
        chk("R2 src", src_is_ext, 1);
        chk_period("R2 period", exp_period(1));
        chk("R6 flag running", fail_flag, 0);
        sel_ext_req = 0;
        wait_cyc(30);
        chk("R3 src", src_is_ext, 0);
        chk_period("R3 period", exp_period(0));

        // R5 failure while selected
        sel_ext_req = 1; irq_en = 1;
        wait_cyc(30);
        chk("R2 src again", src_is_ext, 1);
        ext_on = 0;
        wait_cyc(3);
        chk("R5 not early", fail_flag, 0);
        wait_cyc(20);
        chk("R5 flag", fail_flag, 1);
        chk("R9 irq on", irq, exp_irq(fail_flag, irq_en));
        wait_cyc(10);
        chk("R5 src fallback", src_is_ext, 0);
        chk_period("R5 period fallback", exp_period(0));

        // R7 sticky, R9 masking
        wait_cyc(40);
        chk("R7 sticky", fail_flag, 1);
        irq_en = 0;
        wait_cyc(1);
        chk("R9 irq masked", irq, 0);
        irq_en = 1;
        wait_cyc(1);
        chk("R9 irq unmasked", irq, 1);

        // R8 request ignored while flagged, with a live clock again
        ext_on = 1;
        wait_cyc(40);
        chk("R8 src held", src_is_ext, exp_src(sel_ext_req, fail_flag));
        chk_period("R8 period", exp_period(0));
        pulse_clr;
        chk("R7 cleared", fail_flag, 0);
        chk("R9 irq cleared", irq, 0);
        wait_cyc(40);
        chk("R8 honoured after clear", src_is_ext, 1);
        chk("R7 stays clear", fail_flag, 0);

        // R11 request to an already dead clock
        sel_ext_req = 0;
        wait_cyc(30);
        ext_on = 0;
        wait_cyc(5);
        sel_ext_req = 1;
        wait_cyc(30);
        chk("R11 flag", fail_flag, 1);
        wait_cyc(10);
        chk("R11 src", src_is_ext, 0);
        chk_period("R11 period", exp_period(0));
        ext_on = 1;
        sel_ext_req = 0;
        pulse_clr;
        wait_cyc(10);

        // R10 monitor disabled
        mon_en = 0; sel_ext_req = 1;
        wait_cyc(30);
        chk("R10 src", src_is_ext, 1);
        ext_on = 0;
        wait_cyc(40);
        chk("R10 no flag", fail_flag, 0);
        ext_on = 1;
        wait_cyc(10);
        sel_ext_req = 0;
        wait_cyc(30);
        chk("R10 back", src_is_ext, 0);
        chk("R10 flag still clear", fail_flag, 0);

        // Random requests with a running external clock
        for (int it = 0; it < 30; it++) begin
            sel_ext_req = 1'($urandom_range(0, 1));
            mon_en      = 1'($urandom_range(0, 1));
            irq_en      = 1'($urandom_range(0, 1));
            wait_cyc(25 + $urandom_range(0, 15));
            chk("R2/R3 random src", src_is_ext, exp_src(sel_ext_req, 1'b0));
            chk("R6 random flag", fail_flag, 0);
            chk("R9 random irq", irq, exp_irq(fail_flag, irq_en));
            if (it % 5 == 0) chk_period("R4 random period", exp_period(sel_ext_req));
        end

        chk("R4 min pulse", (min_w >= 2.4) ? 1 : 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule